// File: doc/BRIEF.md
# Shared-Cache Event Counter Bank

This block is a memory-mapped performance monitor for a shared cache. It holds a bank of wide event counters. Each counter picks one line from a vector of event pulses by a programmable 8-bit code. A counter advances by one in every cycle where its chosen line is high, its own enable and the global enable are set, and the event passes the active qualifiers. There are two qualifiers. The first is a 2-bit channel match, which applies only to a fixed window of event codes. The second is a tag qualifier: it can limit counting to read requests, and it can also require an exact 14-bit source identifier.

Software programs the bank over a request/response register bus that uses valid/ready on both sides. A request is taken when `req_valid` and `req_ready` are both high. The response comes back on the next cycle and stays unchanged until `rsp_ready` is seen high. While a response is waiting, `req_ready` is held low, so a slow consumer stalls the requester and no response is ever dropped. The event pulses have no handshake; they are sampled on every clock edge.

When a counter wraps it sets a sticky status bit. A per-counter mask gates those status bits onto one level interrupt line, and writing a one to the clear register removes a status bit.

Top module: `pmu_cache_evcnt`

## Requirements
- R1: Counter n is read and written as a full 64-bit word at address 0x1E00 + 8·n. A write takes effect on the accepting edge, whether or not counting is on, and later increments build on the written value.
- R2: Event codes live in two 32-bit words at 0x1D00 and 0x1D04. Counter n uses byte lane n%4 (bits 8·(n%4)+7 : 8·(n%4)) of word n/4. A qualified counter adds exactly one in each cycle where `ev_pulse[code]` is high.
- R3: The control word is at 0x1C00. Counter n advances only when its enable, bit n, and the global enable, bit 26, are both 1. Otherwise the counter holds its value.
- R4: The channel field is control bits 28:27. A value of 0 disables the channel check. A nonzero value blocks events whose codes lie from 0x47 to 0x59 unless `ev_chan` equals the field. Events with other codes count as if the field were 0.
- R5: The read-only qualifier is active when control bit 29 is 1 and the tag word at 0x1B2C has bit 0 = 1, bit 2 = 1 and bits 9:7 = 4. While it is active, only events with `ev_rd` = 1 count. While it is inactive, `ev_rd` has no effect.
- R6: The source qualifier is active when R5's qualifier is active and tag bit 3 is 1. While it is active, an event counts only if `ev_srcid` equals bits 14:1 of the source word at 0x1B40. That word reads back only bits 14:1.
- R7: A counter that increments from all-ones to zero sets its status bit, bit n of 0x0808, on the same edge. Writing 1 to bit n of 0x080C clears that bit. If a wrap and a clear hit the same bit in one cycle, the bit ends up set. An increment that does not wrap leaves status unchanged.
- R8: `irq` is high exactly when some status bit is 1 and its bit in the mask word at 0x0800 is 0.
- R9: If a bus write and an increment hit the same counter in one cycle, the counter takes the written value, and that cycle sets no status bit.
- R10: The word at 0x1CF0 always returns the VERSION parameter and ignores writes. Unmapped addresses read as zero.
- R11: A response follows one cycle after acceptance. Read data shows the state before the accepting edge. While `rsp_valid` is high and `rsp_ready` is low, the response is held unchanged and `req_ready` stays low.
- R12: After reset, all counters, codes, control, tag, source and status words are zero, the mask word reads 0xFF and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Bank can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address of the register |
| req_wdata | input | 64 | Write data; 32-bit registers use bits 31:0 |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 64 | Read data (zero for writes) |
| ev_pulse | input | 256 | Event pulses indexed by event code |
| ev_chan | input | 2 | Channel of the events in this cycle |
| ev_rd | input | 1 | Events in this cycle are read requests |
| ev_srcid | input | 14 | Source identifier of the events in this cycle |
| irq | output | 1 | Level interrupt |

## Verification
Counter and status updates land on the same edge that samples the pulse or the bus write. Reads return a registered copy taken at the accepting edge, so read data appears one cycle after that edge. The bench drives inputs at falling edges and samples `rsp_rdata` at the next falling edge after acceptance. It checks counters only through later bus reads, which are accepted at least one edge after the pulse edge. `irq` is combinational from registered status and mask, so it is sampled at the falling edge after the write that changes either of them. One read is issued on the same edge as a pulse, and it must return the value from before the increment.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int ADDR_W  = 16;
  localparam int SRCID_W = 14;

  localparam logic [15:0] OFS_IMASK = 16'h0800;
  localparam logic [15:0] OFS_ISTAT = 16'h0808;
  localparam logic [15:0] OFS_ICLR  = 16'h080C;
  localparam logic [15:0] OFS_TAG   = 16'h1B2C;
  localparam logic [15:0] OFS_SRCID = 16'h1B40;
  localparam logic [15:0] OFS_CTRL  = 16'h1C00;
  localparam logic [15:0] OFS_VER   = 16'h1CF0;
  localparam logic [15:0] OFS_SEL   = 16'h1D00;
  localparam logic [15:0] OFS_CNT   = 16'h1E00;

  localparam int CTRL_GLB   = 26;
  localparam int CTRL_CH_LO = 27;
  localparam int CTRL_TAGEN = 29;
  localparam int TAG_MARK   = 0;
  localparam int TAG_REQ    = 2;
  localparam int TAG_SRC    = 3;
  localparam int TAG_TYP_LO = 7;
  localparam int SRCID_LO   = 1;
  localparam int LANE_W     = 8;

  localparam logic [2:0] TAG_TYPE_READ = 3'd4;
  localparam logic [7:0] CH_EV_MIN     = 8'h47;
  localparam logic [7:0] CH_EV_MAX     = 8'h59;

  typedef struct packed {
    logic               glb;
    logic [1:0]         chan;
    logic               rd_only;
    logic               src_on;
    logic [SRCID_W-1:0] srcid;
  } filt_cfg_t;

  function automatic logic [ADDR_W-1:0] sel_addr(input int n);
    return OFS_SEL + ADDR_W'(4 * (n / 4));
  endfunction

  function automatic logic [ADDR_W-1:0] cnt_addr(input int n);
    return OFS_CNT + ADDR_W'(8 * n);
  endfunction
endpackage

// File: rtl/pmu_regfile.sv
module pmu_regfile import pmu_pkg::*; #(
  parameter int          NUM_CNT = 8,
  parameter int          CNT_W   = 64,
  parameter int          EV_W    = 8,
  parameter int          BUS_W   = 64,
  parameter logic [31:0] VERSION = 32'h0000_0021
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [BUS_W-1:0]    req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [BUS_W-1:0]    rsp_rdata,
  input  logic [CNT_W-1:0]    cnt_rd [NUM_CNT],
  input  logic [NUM_CNT-1:0]  status,
  output logic [NUM_CNT-1:0]  cnt_we,
  output logic [CNT_W-1:0]    cnt_wdata,
  output logic                clr_we,
  output logic [NUM_CNT-1:0]  clr_bits,
  output logic [NUM_CNT-1:0]  imask,
  output logic [NUM_CNT-1:0]  cnt_en,
  output filt_cfg_t           cfg,
  output logic [EV_W-1:0]     ev_sel [NUM_CNT]
);
  logic               acc, wr;
  logic               glb_q, tagen_q, mark_q, reqt_q, srcen_q;
  logic [1:0]         chan_q;
  logic [2:0]         ttype_q;
  logic [SRCID_W-1:0] srcid_q;
  logic [BUS_W-1:0]   rd_mux;
  logic               rd_on;

  assign req_ready = ~rsp_valid;
  assign acc       = req_valid & req_ready;
  assign wr        = acc & req_write;
  assign cnt_wdata = req_wdata[CNT_W-1:0];
  assign clr_we    = wr & (req_addr == OFS_ICLR);
  assign clr_bits  = req_wdata[NUM_CNT-1:0];

  always_comb begin
    for (int n = 0; n < NUM_CNT; n++)
      cnt_we[n] = wr & (req_addr == cnt_addr(n));
  end

  // Tag qualifier decode: read-only needs the whole tag path armed.
  assign rd_on       = tagen_q & mark_q & reqt_q & (ttype_q == TAG_TYPE_READ);
  assign cfg.glb     = glb_q;
  assign cfg.chan    = chan_q;
  assign cfg.rd_only = rd_on;
  assign cfg.src_on  = rd_on & srcen_q;
  assign cfg.srcid   = srcid_q;

  always_comb begin
    rd_mux = '0;
    if (req_addr == OFS_IMASK) rd_mux[NUM_CNT-1:0] = imask;
    if (req_addr == OFS_ISTAT) rd_mux[NUM_CNT-1:0] = status;
    if (req_addr == OFS_CTRL) begin
      rd_mux[NUM_CNT-1:0]         = cnt_en;
      rd_mux[CTRL_GLB]            = glb_q;
      rd_mux[CTRL_CH_LO +: 2]     = chan_q;
      rd_mux[CTRL_TAGEN]          = tagen_q;
    end
    if (req_addr == OFS_TAG) begin
      rd_mux[TAG_TYP_LO +: 3] = ttype_q;
      rd_mux[TAG_MARK]        = mark_q;
      rd_mux[TAG_REQ]         = reqt_q;
      rd_mux[TAG_SRC]         = srcen_q;
    end
    if (req_addr == OFS_SRCID) rd_mux[SRCID_LO +: SRCID_W] = srcid_q;
    if (req_addr == OFS_VER)   rd_mux[31:0] = VERSION;
    for (int n = 0; n < NUM_CNT; n++) begin
      if (req_addr == sel_addr(n)) rd_mux[(n % 4) * LANE_W +: EV_W] = ev_sel[n];
      if (req_addr == cnt_addr(n)) rd_mux[CNT_W-1:0] = cnt_rd[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask   <= '1;
      cnt_en  <= '0;
      glb_q   <= 1'b0;
      chan_q  <= '0;
      tagen_q <= 1'b0;
      ttype_q <= '0;
      mark_q  <= 1'b0;
      reqt_q  <= 1'b0;
      srcen_q <= 1'b0;
      srcid_q <= '0;
      for (int n = 0; n < NUM_CNT; n++) ev_sel[n] <= '0;
    end else if (wr) begin
      if (req_addr == OFS_IMASK) imask <= req_wdata[NUM_CNT-1:0];
      if (req_addr == OFS_CTRL) begin
        cnt_en  <= req_wdata[NUM_CNT-1:0];
        glb_q   <= req_wdata[CTRL_GLB];
        chan_q  <= req_wdata[CTRL_CH_LO +: 2];
        tagen_q <= req_wdata[CTRL_TAGEN];
      end
      if (req_addr == OFS_TAG) begin
        ttype_q <= req_wdata[TAG_TYP_LO +: 3];
        mark_q  <= req_wdata[TAG_MARK];
        reqt_q  <= req_wdata[TAG_REQ];
        srcen_q <= req_wdata[TAG_SRC];
      end
      if (req_addr == OFS_SRCID) srcid_q <= req_wdata[SRCID_LO +: SRCID_W];
      for (int n = 0; n < NUM_CNT; n++)
        if (req_addr == sel_addr(n)) ev_sel[n] <= req_wdata[(n % 4) * LANE_W +: EV_W];
    end
  end
endmodule

// File: rtl/pmu_evqual.sv
module pmu_evqual import pmu_pkg::*; #(
  parameter int EV_W = 8
) (
  input  logic [(1<<EV_W)-1:0] ev_pulse,
  input  logic [EV_W-1:0]      code,
  input  logic                 en,
  input  filt_cfg_t            cfg,
  input  logic [1:0]           ev_chan,
  input  logic                 ev_rd,
  input  logic [SRCID_W-1:0]   ev_srcid,
  output logic                 hit
);
  logic in_range, chan_ok, rd_ok, src_ok;

  assign in_range = (code >= EV_W'(CH_EV_MIN)) && (code <= EV_W'(CH_EV_MAX));
  assign chan_ok  = (cfg.chan == 2'd0) || !in_range || (ev_chan == cfg.chan);
  assign rd_ok    = !cfg.rd_only || ev_rd;
  assign src_ok   = !cfg.src_on || (ev_srcid == cfg.srcid);
  assign hit      = en & cfg.glb & ev_pulse[code] & chan_ok & rd_ok & src_ok;
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] q,
  output logic             wrap
);
  // A bus write overrides the increment and suppresses the wrap flag.
  assign wrap = inc & ~we & (&q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (we)  q <= wdata;
    else if (inc) q <= q + CNT_W'(1);
  end
endmodule

// File: rtl/pmu_irq.sv
module pmu_irq #(
  parameter int NUM_CNT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] wrap,
  input  logic               clr_we,
  input  logic [NUM_CNT-1:0] clr_bits,
  input  logic [NUM_CNT-1:0] imask,
  output logic [NUM_CNT-1:0] status,
  output logic               irq
);
  logic [NUM_CNT-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_bits : '0;
  assign irq     = |(status & ~imask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_eff) | wrap;
  end
endmodule

// File: rtl/pmu_cache_evcnt.sv
module pmu_cache_evcnt import pmu_pkg::*; #(
  parameter int          NUM_CNT = 8,
  parameter int          CNT_W   = 64,
  parameter int          EV_W    = 8,
  parameter int          BUS_W   = 64,
  parameter logic [31:0] VERSION = 32'h0000_0021
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [BUS_W-1:0]     req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [BUS_W-1:0]     rsp_rdata,
  input  logic [(1<<EV_W)-1:0] ev_pulse,
  input  logic [1:0]           ev_chan,
  input  logic                 ev_rd,
  input  logic [SRCID_W-1:0]   ev_srcid,
  output logic                 irq
);
  logic [CNT_W-1:0]   cnt_q [NUM_CNT];
  logic [EV_W-1:0]    ev_sel [NUM_CNT];
  logic [NUM_CNT-1:0] cnt_we, inc, wrap, status_q, imask_q, cnt_en, clr_bits;
  logic [CNT_W-1:0]   cnt_wdata;
  logic               clr_we, glb_on;
  filt_cfg_t          cfg;

  assign glb_on = cfg.glb;

  pmu_regfile #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .EV_W(EV_W), .BUS_W(BUS_W),
                .VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .cnt_rd(cnt_q), .status(status_q), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .clr_we(clr_we), .clr_bits(clr_bits), .imask(imask_q), .cnt_en(cnt_en),
    .cfg(cfg), .ev_sel(ev_sel)
  );

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    pmu_evqual #(.EV_W(EV_W)) u_qual (
      .ev_pulse(ev_pulse), .code(ev_sel[n]), .en(cnt_en[n]), .cfg(cfg),
      .ev_chan(ev_chan), .ev_rd(ev_rd), .ev_srcid(ev_srcid), .hit(inc[n])
    );
    pmu_counter #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .inc(inc[n]), .we(cnt_we[n]),
      .wdata(cnt_wdata), .q(cnt_q[n]), .wrap(wrap[n])
    );
  end

  pmu_irq #(.NUM_CNT(NUM_CNT)) u_irq (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .clr_we(clr_we), .clr_bits(clr_bits),
    .imask(imask_q), .status(status_q), .irq(irq)
  );
endmodule

// File: rtl/pmu_evcnt_chk.sv
module pmu_evcnt_chk #(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 64,
  parameter int BUS_W   = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [BUS_W-1:0]   rsp_rdata,
  input logic               irq,
  input logic [NUM_CNT-1:0] imask,
  input logic [NUM_CNT-1:0] status,
  input logic               clr_we,
  input logic               glb,
  input logic               cnt0_we,
  input logic [CNT_W-1:0]   cnt0
);
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_busy_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status & ~imask) != '0));

  assert_irq_raised_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~imask) != '0) |-> irq);

  assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((status & $past(status)) == $past(status)));

  assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb && !cnt0_we) |=> $stable(cnt0));
endmodule

bind pmu_cache_evcnt pmu_evcnt_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .irq(irq), .imask(imask_q),
  .status(status_q), .clr_we(clr_we), .glb(glb_on), .cnt0_we(cnt_we[0]),
  .cnt0(cnt_q[0])
);

// File: tb/sim_pmu_cache_evcnt.sv
module sim_pmu_cache_evcnt;
  localparam logic [15:0] A_MASK = 16'h0800, A_STAT = 16'h0808, A_CLR = 16'h080C;
  localparam logic [15:0] A_TAG  = 16'h1B2C, A_SRC  = 16'h1B40, A_CTRL = 16'h1C00;
  localparam logic [15:0] A_VER  = 16'h1CF0, A_SEL0 = 16'h1D00, A_SEL1 = 16'h1D04;
  localparam logic [31:0] VER    = 32'h0000_0021;
  localparam logic [63:0] GLB    = 64'h1 << 26;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1, ev_rd = 0;
  logic [15:0]  req_addr = '0;
  logic [63:0]  req_wdata = '0;
  logic [255:0] ev_pulse = '0;
  logic [1:0]   ev_chan = '0;
  logic [13:0]  ev_srcid = '0;
  logic req_ready, rsp_valid, irq;
  logic [63:0] rsp_rdata;

  int vectors = 0, miscompares = 0;
  logic done = 0;
  logic [63:0] exp_c [8];
  logic [63:0] r;

  always #5 clk = ~clk;

  pmu_cache_evcnt u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .ev_pulse(ev_pulse), .ev_chan(ev_chan), .ev_rd(ev_rd), .ev_srcid(ev_srcid),
    .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic xfer(input logic w, input logic [15:0] a, input logic [63:0] d,
                      input logic [255:0] p, output logic [63:0] rd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; ev_pulse = p;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; ev_pulse = '0;
    rd = rsp_rdata;
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    logic [63:0] dummy;
    xfer(1'b1, a, d, '0, dummy);
  endtask

  task automatic rd(input logic [15:0] a, output logic [63:0] v);
    xfer(1'b0, a, 64'h0, '0, v);
  endtask

  task automatic pulse(input logic [255:0] p);
    @(negedge clk);
    ev_pulse = p;
    @(posedge clk);
    @(negedge clk);
    ev_pulse = '0;
  endtask

  function automatic logic [15:0] ca(input int n);
    return 16'h1E00 + 16'(8 * n);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) exp_c[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R12: reset values
    check("R12 irq", {63'b0, irq}, 64'h0);
    rd(A_MASK, r); check("R12 mask", r, 64'hFF);
    rd(A_CTRL, r); check("R12 ctrl", r, 64'h0);
    rd(A_STAT, r); check("R12 status", r, 64'h0);
    rd(A_TAG, r);  check("R12 tag", r, 64'h0);
    rd(A_SEL0, r); check("R12 sel", r, 64'h0);
    for (int n = 0; n < 8; n++) begin rd(ca(n), r); check("R12 counter", r, 64'h0); end

    // R10: version is read-only, unmapped reads zero
    wr(A_VER, 64'hFFFF_FFFF);
    rd(A_VER, r); check("R10 version", r, {32'h0, VER});
    rd(16'h0004, r); check("R10 unmapped", r, 64'h0);

    // R2: code routing sweep over all 256 codes
    wr(A_CTRL, GLB | 64'hFF);
    for (int b = 0; b < 32; b++) begin
      logic [255:0] p1, p2;
      logic [31:0] w0, w1;
      p1 = '0; p2 = '0;
      for (int i = 0; i < 8; i++) begin
        logic [7:0] c;
        c = 8'(b * 8 + i);
        if (i < 4) w0[i*8 +: 8] = c; else w1[(i-4)*8 +: 8] = c;
        p2[c] = 1'b1;
        if ((i + b) % 3 != 0) p1[c] = 1'b1;
      end
      wr(A_SEL0, {32'h0, w0});
      wr(A_SEL1, {32'h0, w1});
      pulse(p1);
      pulse(p2);
      for (int i = 0; i < 8; i++) begin
        exp_c[i] = exp_c[i] + (((i + b) % 3 != 0) ? 64'd2 : 64'd1);
        rd(ca(i), r); check("R2 routing", r, exp_c[i]);
      end
    end

    // R3: enable mask sweep with global on
    for (int m = 0; m < 256; m++) begin
      wr(A_CTRL, GLB | 64'(m));
      pulse('1);
      for (int i = 0; i < 8; i++) begin
        if (m[i]) exp_c[i] = exp_c[i] + 64'd1;
        rd(ca(i), r); check("R3 enable", r, exp_c[i]);
      end
    end
    // R3: global off holds every counter
    wr(A_CTRL, 64'hFF);
    pulse('1);
    for (int i = 0; i < 8; i++) begin rd(ca(i), r); check("R3 global off", r, exp_c[i]); end

    // R4: channel filter sweep on counter 0
    for (int f = 0; f < 4; f++) begin
      wr(A_CTRL, GLB | 64'h1 | (64'(f) << 27));
      for (int c = 0; c < 256; c++) begin
        wr(A_SEL0, 64'(c));
        for (int ch = 0; ch < 4; ch++) begin
          ev_chan = 2'(ch);
          pulse(256'd1 << c);
          if (f == 0 || c < 8'h47 || c > 8'h59 || ch == f) exp_c[0] = exp_c[0] + 64'd1;
        end
        rd(ca(0), r); check("R4 channel", r, exp_c[0]);
      end
    end
    ev_chan = 2'd0;

    // R6: source word keeps only bits 14:1
    wr(A_SRC, 64'hFFFF_FFFF);
    rd(A_SRC, r); check("R6 srcid readback", r, 64'h7FFE);
    wr(A_SRC, 64'(14'h1A5) << 1);

    // R5/R6: tag qualifier sweep
    wr(A_SEL0, 64'h5);
    for (int t = 0; t < 128; t++) begin
      logic rd_on, src_on;
      rd_on  = t[6] && t[3] && t[4] && (t[2:0] == 3'd4);
      src_on = rd_on && t[5];
      wr(A_CTRL, GLB | 64'h1 | (64'(t[6]) << 29));
      wr(A_TAG, (64'(t[2:0]) << 7) | (64'(t[5]) << 3) | (64'(t[4]) << 2) | 64'(t[3]));
      for (int e = 0; e < 4; e++) begin
        ev_rd = e[0];
        ev_srcid = e[1] ? 14'h1A5 : 14'h1A4;
        pulse(256'h20);
        if ((!rd_on || e[0]) && (!src_on || e[1])) exp_c[0] = exp_c[0] + 64'd1;
      end
      rd(ca(0), r); check("R5 R6 tag", r, exp_c[0]);
    end
    ev_rd = 0; ev_srcid = '0;
    wr(A_CTRL, GLB | 64'hFF);
    wr(A_SEL0, 64'h0302_0100);
    wr(A_SEL1, 64'h0706_0504);

    // R1: counter write and subsequent count
    wr(ca(7), 64'hDEAD_BEEF_0123_4567);
    rd(ca(7), r); check("R1 write", r, 64'hDEAD_BEEF_0123_4567);
    pulse(256'h80);
    rd(ca(7), r); check("R1 count after write", r, 64'hDEAD_BEEF_0123_4568);

    // R11: read on a pulse edge returns pre-edge state
    xfer(1'b0, ca(7), 64'h0, 256'h80, r);
    check("R11 pre-edge read", r, 64'hDEAD_BEEF_0123_4568);
    rd(ca(7), r); check("R11 post-edge", r, 64'hDEAD_BEEF_0123_4569);

    // R7: non-wrapping increment leaves status clear
    wr(ca(6), 64'hFFFF_FFFF_FFFF_FFFE);
    pulse(256'h40);
    rd(ca(6), r); check("R7 near wrap", r, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(A_STAT, r); check("R7 no status", r, 64'h0);
    // R7/R8: wrap sets status, masked irq stays low
    wr(ca(3), 64'hFFFF_FFFF_FFFF_FFFF);
    pulse(256'h08);
    rd(ca(3), r); check("R7 wrap value", r, 64'h0);
    rd(A_STAT, r); check("R7 wrap status", r, 64'h08);
    check("R8 masked irq", {63'b0, irq}, 64'h0);
    wr(A_MASK, 64'hF7);
    check("R8 unmasked irq", {63'b0, irq}, 64'h1);
    wr(A_CLR, 64'h08);
    rd(A_STAT, r); check("R7 cleared", r, 64'h0);
    check("R8 irq after clear", {63'b0, irq}, 64'h0);
    // R7: wrap and clear in one cycle leaves the bit set
    wr(A_MASK, 64'hDF);
    wr(ca(5), 64'hFFFF_FFFF_FFFF_FFFF);
    xfer(1'b1, A_CLR, 64'h20, 256'h20, r);
    rd(A_STAT, r); check("R7 set wins", r, 64'h20);
    check("R8 irq bit5", {63'b0, irq}, 64'h1);
    wr(A_CLR, 64'hFF);
    check("R8 irq cleared", {63'b0, irq}, 64'h0);

    // R9: bus write beats a same-cycle increment
    xfer(1'b1, ca(2), 64'h1234, 256'h04, r);
    rd(ca(2), r); check("R9 write wins", r, 64'h1234);
    xfer(1'b1, ca(2), 64'hFFFF_FFFF_FFFF_FFFF, 256'h04, r);
    rd(ca(2), r); check("R9 all-ones write", r, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(A_STAT, r); check("R9 no status", r, 64'h0);

    // R11: back-pressure holds response and stalls requests
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_addr = A_VER;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k < 3; k++) begin
      check("R11 stall ready", {63'b0, req_ready}, 64'h0);
      check("R11 hold valid", {63'b0, rsp_valid}, 64'h1);
      check("R11 hold data", rsp_rdata, {32'h0, VER});
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    check("R11 released", {63'b0, rsp_valid}, 64'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule